// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block runs the bus side of a two-wire serial link as the only master on it. A command carries a 7-bit target address, a direction flag and a byte count. The controller sends a start condition and then the address byte with the direction in its lowest bit. After that it either streams write bytes out and checks the target's acknowledge after each one, or streams read bytes in and acknowledges them itself. It ends every command with a stop condition and pulses `done`, with `nack` giving the outcome.

Both bus lines are open-drain. The block only has an enable that pulls each line low. It never drives a line high, and it reads each line back through a two-stage synchroniser. A quarter-period tick engine splits every SCL cycle into four phases. SDA is updated in the middle of the low half and sampled in the middle of the high half. When SCL is released, the tick engine stops until the line actually reads high, so a target that stretches the clock is waited for.

Write data enters on a valid/ready stream and read data leaves on one. `wr_ready` is raised only when the next byte is needed, with SCL already held low. The bus stays parked there until `wr_valid` is seen, so a source that stalls simply lengthens the clock low time. In the same way, `rd_valid` holds a received byte with SCL parked low until `rd_ready` accepts it. The acknowledge clock for that byte follows only after acceptance. While `rd_valid` waits, `rd_data` does not change.

Top module: `i2cm_xfer`

## Requirements
- R1: After reset, and at any reset during a transfer, both line enables are low, `cmd_ready` is high, and `wr_ready`, `rd_valid` and `done` are low.
- R2: A command starts with SDA pulled low while SCL is released, followed by SCL pulled low. Between the start and the stop, SDA changes only while SCL is pulled low.
- R3: The first byte is `{cmd_addr, cmd_read}`, sent most significant bit first, where 1 means read and 0 means write. Its ninth clock is given with SDA released so that the target can acknowledge.
- R4: On a write, each byte is taken from the write stream through a `wr_valid`/`wr_ready` handshake and sent MSB first, followed by an acknowledge clock. `wr_ready` is high only while SCL is held low waiting for data.
- R5: If SDA is sampled high in the acknowledge clock after the address or after a written byte, no further bytes are requested. The controller issues a stop and pulses `done` with `nack` = 1. Otherwise `nack` = 0 at `done`.
- R6: On a read, eight bits are sampled MSB first and presented on `rd_data` with `rd_valid`. They stay stable, with SCL held low, until `rd_ready`. After acceptance the controller pulls SDA low during the ninth clock for every byte except the last.
- R7: For the last byte of a read, SDA stays released during the ninth clock (no acknowledge), and the stop follows.
- R8: The stop is SDA released while SCL is released. `done` pulses for one cycle as the controller returns to idle with both lines released.
- R9: While SCL is released but reads low (a target stretching the clock), the controller does not advance. The sampling point and the next falling edge are both measured from the moment SCL is seen high.
- R10: A command with `cmd_len` = 0 sends only the address byte and its acknowledge clock, then the stop.
- R11: Unstretched, each SCL high time lasts `2*QTR_CLKS` system clocks plus the synchroniser delay, at most 4 clocks more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command accepted when both high |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len | input | LEN_W | Number of data bytes (0 allowed) |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Controller takes the write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer takes the received byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse when the stop has completed |
| nack | output | 1 | Outcome of the last command, valid from `done` |
| scl_oe | output | 1 | Pull SCL low when high |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | SDA line level |

## Verification
The line-level assertions assume that the target changes SDA only while SCL is low. They also assume that any clock stretch ends eventually, so a released SCL reads high in the end. The handshake assertion assumes that `rd_ready` is the only thing that releases a pending byte. The bench's target model reacts only to a falling SCL edge it has already seen: it drives acknowledge and read bits from there, and it holds SCL low only after it sees SCL low. Start and stop conditions therefore come only from the controller. Write and read streams are throttled with fixed duty patterns, so the stalls land at different bus positions without breaking the handshake rules.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_WWAIT,
    ST_RWAIT,
    ST_STOP
  } ctl_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int QTR_CLKS = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       scl_high,
  output logic       tick,
  output logic [1:0] qtr
);
  localparam int CNT_W = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QTR_CLKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             stall;

  // quarter 2 is the released-SCL quarter: it only counts once the line reads high
  assign stall = (qtr == 2'd2) && !scl_high;
  assign tick  = run && !stall && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      qtr <= 2'd0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!stall) begin
      if (cnt == LAST) begin
        cnt <= '0;
        qtr <= qtr + 2'd1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    run && qtr == 2'd2 && !scl_high |=> qtr == 2'd2 && $stable(cnt)); // R9
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], bit_in};
  end

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R3
endmodule

// File: rtl/i2cm_xfer.sv
module i2cm_xfer #(
  parameter int QTR_CLKS = 125,
  parameter int LEN_W    = 4,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_read,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             nack,
  output logic             scl_oe,
  input  logic             scl_in,
  output logic             sda_oe,
  input  logic             sda_in
);
  import i2cm_pkg::*;

  localparam int BIT_IW = $clog2(BYTE_W);
  localparam logic [BIT_IW-1:0] LAST_BIT = BIT_IW'(BYTE_W - 1);

  ctl_state_e        state;
  logic              scl_lo, sda_lo;
  logic [BIT_IW-1:0] bit_idx;
  logic              addr_ph, rd_mode, nack_r, done_r, nack_out;
  logic [LEN_W-1:0]  left;
  logic [SYNC_N-1:0] scl_sy, sda_sy;
  logic              scl_s, sda_s;
  logic              run, tick;
  logic [1:0]        qtr, qn;
  logic              more, ack_rd;
  logic              sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_din, sh_q;

  // line synchronisers, idle-high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[SYNC_N-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_N-2:0], sda_in};
    end
  end
  assign scl_s = scl_sy[SYNC_N-1];
  assign sda_s = sda_sy[SYNC_N-1];

  assign run = (state == ST_START) || (state == ST_BIT) ||
               (state == ST_ACK)   || (state == ST_STOP);

  i2cm_tick #(.QTR_CLKS(QTR_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .scl_high(scl_s),
    .tick(tick), .qtr(qtr)
  );

  assign qn     = qtr + 2'd1;
  assign ack_rd = rd_mode && !addr_ph;
  // another byte follows the current one
  assign more   = addr_ph ? (left != '0) : (left > LEN_W'(1));

  always_comb begin
    sh_load = 1'b0;
    sh_din  = '1;
    if (state == ST_IDLE && cmd_valid) begin
      sh_load = 1'b1;
      sh_din  = {cmd_addr, cmd_read};
    end else if (state == ST_WWAIT && wr_valid) begin
      sh_load = 1'b1;
      sh_din  = wr_data;
    end else if (state == ST_ACK && tick && qn == 2'd0 && !nack_r && more && rd_mode) begin
      sh_load = 1'b1;
      sh_din  = '1;
    end
  end
  assign sh_shift = tick && (state == ST_BIT) && (qn == 2'd3);

  i2cm_shreg #(.W(BYTE_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(sh_din),
    .shift(sh_shift), .bit_in(sda_s), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      scl_lo   <= 1'b0;
      sda_lo   <= 1'b0;
      bit_idx  <= '0;
      addr_ph  <= 1'b0;
      rd_mode  <= 1'b0;
      left     <= '0;
      nack_r   <= 1'b0;
      done_r   <= 1'b0;
      nack_out <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          rd_mode <= cmd_read;
          left    <= cmd_len;
          addr_ph <= 1'b1;
          nack_r  <= 1'b0;
          state   <= ST_START;
        end
        ST_START: if (tick) begin
          if (qn == 2'd2) sda_lo <= 1'b1;
          if (qn == 2'd3) scl_lo <= 1'b1;
          if (qn == 2'd0) begin
            state   <= ST_BIT;
            bit_idx <= '0;
          end
        end
        ST_BIT: if (tick) begin
          if (qn == 2'd1) sda_lo <= !sh_q[BYTE_W-1];
          if (qn == 2'd2) scl_lo <= 1'b0;
          if (qn == 2'd0) begin
            scl_lo <= 1'b1;
            if (bit_idx == LAST_BIT) state <= ack_rd ? ST_RWAIT : ST_ACK;
            else                     bit_idx <= bit_idx + BIT_IW'(1);
          end
        end
        ST_RWAIT: if (rd_ready) state <= ST_ACK;
        ST_ACK: if (tick) begin
          if (qn == 2'd1) sda_lo <= ack_rd && more;
          if (qn == 2'd2) scl_lo <= 1'b0;
          if (qn == 2'd3 && !ack_rd && sda_s) nack_r <= 1'b1;
          if (qn == 2'd0) begin
            scl_lo  <= 1'b1;
            sda_lo  <= 1'b0;
            addr_ph <= 1'b0;
            bit_idx <= '0;
            if (!addr_ph) left <= left - LEN_W'(1);
            if (nack_r || !more) state <= ST_STOP;
            else if (rd_mode)    state <= ST_BIT;
            else                 state <= ST_WWAIT;
          end
        end
        ST_WWAIT: if (wr_valid) state <= ST_BIT;
        ST_STOP: if (tick) begin
          if (qn == 2'd1) sda_lo <= 1'b1;
          if (qn == 2'd2) scl_lo <= 1'b0;
          if (qn == 2'd3) sda_lo <= 1'b0;
          if (qn == 2'd0) begin
            state    <= ST_IDLE;
            done_r   <= 1'b1;
            nack_out <= nack_r;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign wr_ready  = (state == ST_WWAIT);
  assign rd_valid  = (state == ST_RWAIT);
  assign rd_data   = sh_q;
  assign done      = done_r;
  assign nack      = nack_out;
  assign scl_oe    = scl_lo;
  assign sda_oe    = sda_lo;

  AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BIT || state == ST_ACK) && !scl_lo && $past(!scl_lo) |-> $stable(sda_lo)); // R2
  AST_WR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> scl_oe); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && scl_oe); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !scl_oe && !sda_oe); // R8
endmodule

// File: tb/sim_i2cm_xfer.sv
module sim_i2cm_xfer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int QC = 4;
  localparam int LW = 4;
  localparam int NV = 7;
  // {addr[25:19], rw[18], len[17:14], nack_at[13:10], seed[9:2], stretch[1], slow[0]}
  localparam logic [25:0] VECS [0:NV-1] = '{
    {7'h50, 1'b0, 4'd3, 4'd15, 8'h11, 1'b0, 1'b0},
    {7'h2B, 1'b1, 4'd4, 4'd15, 8'hC3, 1'b0, 1'b1},
    {7'h7F, 1'b0, 4'd4, 4'd2,  8'h3C, 1'b0, 1'b1},
    {7'h01, 1'b1, 4'd2, 4'd0,  8'h99, 1'b0, 1'b0},
    {7'h44, 1'b0, 4'd0, 4'd15, 8'h07, 1'b0, 1'b0},
    {7'h66, 1'b1, 4'd1, 4'd15, 8'hE1, 1'b1, 1'b0},
    {7'h35, 1'b0, 4'd2, 4'd15, 8'h5D, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_read = 0;
  logic [6:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 0, done, nack;
  logic [7:0] wr_data = '0, rd_data;
  logic scl_oe, sda_oe, slv_scl = 0, slv_sda = 0;
  logic scl_bus, sda_bus;
  assign scl_bus = !scl_oe && !slv_scl;
  assign sda_bus = !sda_oe && !slv_sda;

  always #2.5ns clk = ~clk;

  i2cm_xfer #(.QTR_CLKS(QC), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_read(cmd_read), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .nack(nack), .scl_oe(scl_oe), .scl_in(scl_bus),
    .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  int checks = 0, errors = 0;

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return s + 8'(i * 29);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model
  logic [3:0] cfg_nack = 4'd15;
  logic [7:0] cfg_seed = '0;
  bit cfg_stretch = 0;
  logic [7:0] sl_log [0:15];
  bit sl_mack [0:15];
  int sl_nlog, sl_nmack, sl_starts, sl_stops, hold, hi, hi_min, hi_max;
  int rc, byte_no;
  bit in_frame, is_read, drv, last_mack, prev_scl, prev_sda;
  logic [7:0] sh, rb;

  task automatic clear_logs();
    sl_nlog = 0; sl_nmack = 0; sl_starts = 0; sl_stops = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      in_frame = 0; slv_sda = 0; slv_scl = 0; hold = 0; rc = 0; byte_no = 0;
      drv = 0; prev_scl = 1; prev_sda = 1;
    end else begin
      if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
        sl_starts++; in_frame = 1; rc = 0; byte_no = 0; drv = 0; last_mack = 0; slv_sda = 0;
      end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
        sl_stops++; in_frame = 0; drv = 0; slv_sda = 0;
      end else if (in_frame) begin
        if (scl_bus) hi++;
        if (!prev_scl && scl_bus) begin
          hi = 1;
          if (rc < 8) sh = {sh[6:0], sda_bus};
          else if (byte_no > 0 && is_read) begin
            sl_mack[sl_nmack] = sda_bus; sl_nmack++; last_mack = sda_bus;
          end
          rc++;
        end
        if (prev_scl && !scl_bus) begin
          if (rc > 0) begin
            if (hi < hi_min) hi_min = hi;
            if (hi > hi_max) hi_max = hi;
          end
          if (rc == 8) begin
            if (cfg_stretch) hold = 3 * QC + 5;
            if (byte_no == 0) is_read = sh[0];
            if (byte_no == 0 || !is_read) begin
              sl_log[sl_nlog] = sh; sl_nlog++;
              slv_sda = (4'(byte_no) != cfg_nack);
            end else slv_sda = 0;
          end else if (rc == 9) begin
            rc = 0; byte_no++; slv_sda = 0;
            drv = is_read && (cfg_nack != 0) && !last_mack;
            rb = pat(cfg_seed, byte_no - 1);
            if (drv) slv_sda = !rb[7];
          end else if (rc >= 1 && drv) slv_sda = !rb[7-rc];
        end
      end
      prev_scl = scl_bus;
      prev_sda = sda_bus;
      if (hold > 0) begin hold--; slv_scl = 1; end else slv_scl = 0;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [7:0] rd_got [0:15];

  task automatic run_vec(input logic [25:0] v);
    logic [6:0] a; bit rw, str, slow; int len, nk, widx, ridx, cyc, exp_w, exp_r;
    logic [7:0] seed; bit hs_w, got_nack, exp_nack, seen_done;
    a = v[25:19]; rw = v[18]; len = v[17:14]; nk = v[13:10]; seed = v[9:2]; str = v[1]; slow = v[0];
    cfg_nack = 4'(nk); cfg_seed = seed; cfg_stretch = str;
    clear_logs();
    widx = 0; ridx = 0; cyc = 0; hs_w = 0; seen_done = 0; got_nack = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_read = rw; cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 0;
    while (!seen_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (hs_w) widx++;
      wr_data = pat(seed, widx);
      wr_valid = !rw && (slow ? (cyc % 5 != 0) : 1'b1);
      hs_w = wr_valid && wr_ready;
      rd_ready = slow ? (cyc % 7 < 2) : 1'b1;
      if (rd_valid && rd_ready) begin rd_got[ridx] = rd_data; ridx++; end
      if (done) begin seen_done = 1; got_nack = nack; end
    end
    wr_valid = 0; rd_ready = 0;
    exp_nack = rw ? (nk == 0) : (nk <= len);
    exp_w = rw ? 0 : ((nk == 0) ? 0 : ((nk <= len) ? nk : len));
    exp_r = (rw && nk != 0) ? len : 0;
    chk(seen_done, "R8 done pulse", seen_done, 1);
    chk(sl_log[0] == {a, rw}, "R3 address byte", sl_log[0], {a, rw});
    chk(got_nack == exp_nack, "R5 nack result", got_nack, exp_nack);
    chk(widx == exp_w, "R4 write handshakes", widx, exp_w);
    chk(sl_nlog == 1 + exp_w, "R4 bytes seen by target", sl_nlog, 1 + exp_w);
    for (int i = 0; i < exp_w && i + 1 < sl_nlog; i++)
      chk(sl_log[i+1] == pat(seed, i), "R4 write data", sl_log[i+1], pat(seed, i));
    chk(ridx == exp_r, "R6 read handshakes", ridx, exp_r);
    for (int i = 0; i < exp_r && i < ridx; i++)
      chk(rd_got[i] == pat(seed, i), "R6 read data", rd_got[i], pat(seed, i));
    chk(sl_nmack == exp_r, "R6 master ack count", sl_nmack, exp_r);
    for (int i = 0; i < exp_r && i < sl_nmack; i++)
      chk(sl_mack[i] == (i == exp_r - 1), "R7 master ack level", sl_mack[i], (i == exp_r - 1));
    chk(sl_starts == 1, "R2 one start", sl_starts, 1);
    chk(sl_stops == 1, "R8 one stop", sl_stops, 1);
    chk(cmd_ready && !scl_oe && !sda_oe, "R8 idle after stop", {cmd_ready, scl_oe, sda_oe}, 3'b100);
    if (len == 0) chk(sl_nlog == 1 && widx == 0, "R10 address only", sl_nlog, 1);
  endtask

  initial begin
    logic [7:0] held;
    hi_min = 1000; hi_max = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !scl_oe && !sda_oe && !wr_ready && !rd_valid && !done,
        "R1 reset state", {cmd_ready, scl_oe, sda_oe, wr_ready, rd_valid, done}, 6'b100000);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k]);
      repeat (5) @(negedge clk);
    end

    // R6 back-pressure: single read byte held with rd_ready low
    cfg_nack = 4'd15; cfg_seed = 8'h5A; cfg_stretch = 0;
    clear_logs();
    @(negedge clk);
    cmd_valid = 1; cmd_addr = 7'h12; cmd_read = 1; cmd_len = LW'(1);
    @(negedge clk);
    cmd_valid = 0;
    for (int c = 0; c < 5000 && !rd_valid; c++) @(negedge clk);
    held = rd_data;
    repeat (40) @(negedge clk);
    chk(rd_valid && scl_oe && rd_data == held, "R6 byte held under back-pressure",
        {rd_valid, scl_oe, rd_data}, {2'b11, held});
    chk(held == pat(8'h5A, 0), "R6 held byte value", held, pat(8'h5A, 0));
    chk(sl_nmack == 0, "R6 no ack clock before acceptance", sl_nmack, 0);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    chk(done && !nack, "R8 done after single read", {done, nack}, 2'b10);
    chk(sl_nmack == 1 && sl_mack[0] == 1'b1, "R7 last byte not acked", sl_mack[0], 1);
    repeat (5) @(negedge clk);

    // R11 / R9 high time across all runs, stretched or not
    chk(hi_min >= 2 * QC && hi_max <= 2 * QC + 4, "R11 SCL high time min", hi_min, 2 * QC);
    chk(hi_max <= 2 * QC + 4, "R9 high time after stretch", hi_max, 2 * QC + 4);

    // R1 reset during a write
    clear_logs(); cfg_stretch = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_addr = 7'h21; cmd_read = 0; cmd_len = LW'(3);
    @(negedge clk);
    cmd_valid = 0; wr_valid = 1; wr_data = 8'h00;
    repeat (200) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !wr_ready && !done,
        "R1 reset mid-transfer", {scl_oe, sda_oe, cmd_ready, wr_ready}, 4'b0010);
    wr_valid = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule